// File: doc/BRIEF.md
# 8-bit Arithmetic Unit with Flag Register

This block performs one arithmetic or logic operation per cycle on two operands and keeps a status byte of flags that records what that operation produced. There are eight operations: add, add with carry, subtract, increment, decrement, AND, OR and XOR. The carry for add-with-carry comes from the flag register itself. Each operation updates only the flags that belong to it. The three mask bits of the status byte change only when a whole byte is written through the register write port.

A small condition tester reads the zero and carry flags and reports whether one of four conditional branches would be taken: on equal, on not equal, on carry clear and on carry set. The result, the status byte and the branch decision are all registered.

The status byte has a fixed layout. From the most significant bit down it holds: stop disable, high-priority interrupt mask, half carry, interrupt mask, negative, zero, overflow and carry.

Top module: `alu_ccr_unit`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `result` is 0, `br_taken` is 0 and `ccr` is 0xD0. This means the two interrupt masks and the stop-disable bit are 1 and every other flag is 0.
- R2: When `op_valid` is high, `op_sel` 0 (add) registers a+b and `op_sel` 1 (add with carry) registers a+b+ccr[0]. ccr[0] takes the carry out of bit 7.
- R3: `op_sel` 2 (subtract) registers a-b modulo 256. ccr[0] is set to 1 exactly when a < b, taken as unsigned values.
- R4: `op_sel` 3 (increment) registers a+1 and `op_sel` 4 (decrement) registers a-1. ccr[0] is unchanged. ccr[1] is 1 only when increment starts from 0x7F or decrement starts from 0x80.
- R5: `op_sel` 5, 6 and 7 register a AND b, a OR b and a XOR b. ccr[1] is cleared and ccr[0] is unchanged.
- R6: After every operation, ccr[3] equals bit 7 of the new result, and ccr[2] is 1 exactly when the new result is zero.
- R7: For add, add with carry and subtract, ccr[1] is set on two's-complement overflow. For an add this means both operands have the same sign and the result sign differs. For a subtract it means the operand signs differ and the result sign differs from a.
- R8: ccr[5] takes the carry out of bit 3 on add and add with carry. All other operations leave it unchanged.
- R9: No operation changes ccr[7], ccr[6] or ccr[4].
- R10: When `ccr_wr_en` is high, `ccr` equals `ccr_wr_data` on the next cycle. This holds even when `op_valid` is high in the same cycle. In that case `result` is still updated, and add with carry uses the old ccr[0].
- R11: With `op_valid` and `ccr_wr_en` both low, `result` and `ccr` keep their values.
- R12: `br_taken` shows, one cycle later, the condition picked by `br_sel`, tested on the `ccr` value present at the clock edge. The codes are: 0 is taken when ccr[2]=1, 1 when ccr[2]=0, 2 when ccr[0]=0, and 3 when ccr[0]=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | Perform the selected operation this cycle |
| op_sel | input | 3 | Operation code (see R2 to R5) |
| opnd_a | input | 8 | First operand |
| opnd_b | input | 8 | Second operand |
| ccr_wr_en | input | 1 | Load the flag register from `ccr_wr_data` |
| ccr_wr_data | input | 8 | Byte written to the flag register |
| br_sel | input | 2 | Branch condition select |
| result | output | 8 | Registered operation result |
| ccr | output | 8 | Flag register value |
| br_taken | output | 1 | Registered branch decision |

## Verification
An operation and a register write can both target the flag byte in the same cycle. The bench provokes this by raising `op_valid` and `ccr_wr_en` together, with an add-with-carry whose carry-in differs from the written byte. It then checks three things: the written byte wins entirely, the result still reflects the operation, and the result used the old carry. The branch tester also samples the flag byte in the cycle that an operation overwrites it. For that reason every sweep vector checks `br_taken` against the preset flags and not against the flags the operation produced.

// File: rtl/alu_ccr_pkg.sv
package alu_ccr_pkg;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_ADC = 3'd1,
    OP_SUB = 3'd2,
    OP_INC = 3'd3,
    OP_DEC = 3'd4,
    OP_AND = 3'd5,
    OP_OR  = 3'd6,
    OP_XOR = 3'd7
  } alu_op_e;

  typedef enum logic [1:0] {
    BR_EQ = 2'd0,
    BR_NE = 2'd1,
    BR_CC = 2'd2,
    BR_CS = 2'd3
  } br_cond_e;

  localparam int FLG_C = 0;
  localparam int FLG_V = 1;
  localparam int FLG_Z = 2;
  localparam int FLG_N = 3;
  localparam int FLG_I = 4;
  localparam int FLG_H = 5;
  localparam int FLG_X = 6;
  localparam int FLG_S = 7;

  localparam logic [7:0] CCR_RESET = 8'hD0;

  typedef struct packed {
    logic carry;
    logic ovf;
    logic half;
    logic arith;
  } core_flags_t;

endpackage

// File: rtl/alu_core.sv
module alu_core
  import alu_ccr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  alu_op_e          op,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] res,
  output core_flags_t      flg
);
  localparam int HALF = WIDTH / 2;

  logic [WIDTH-1:0] y;
  logic [WIDTH-1:0] sum;
  logic [WIDTH:0]   cy;
  logic             c0;
  logic             is_arith;
  logic             is_sub;

  always_comb begin
    y        = b;
    c0       = 1'b0;
    is_arith = 1'b1;
    is_sub   = 1'b0;
    unique case (op)
      OP_ADD: begin y = b;                c0 = 1'b0; end
      OP_ADC: begin y = b;                c0 = cin;  end
      OP_SUB: begin y = ~b;               c0 = 1'b1; is_sub = 1'b1; end
      OP_INC: begin y = '0;               c0 = 1'b1; end
      OP_DEC: begin y = {WIDTH{1'b1}};    c0 = 1'b0; end
      default: begin y = b;               c0 = 1'b0; is_arith = 1'b0; end
    endcase
  end

  assign cy[0] = c0;

  for (genvar gi = 0; gi < WIDTH; gi++) begin : g_ripple
    assign sum[gi]   = a[gi] ^ y[gi] ^ cy[gi];
    assign cy[gi+1]  = (a[gi] & y[gi]) | (cy[gi] & (a[gi] ^ y[gi]));
  end

  always_comb begin
    unique case (op)
      OP_AND:  res = a & b;
      OP_OR:   res = a | b;
      OP_XOR:  res = a ^ b;
      default: res = sum;
    endcase
  end

  assign flg.carry = is_sub ? ~cy[WIDTH] : cy[WIDTH];
  assign flg.ovf   = is_arith & (cy[WIDTH] ^ cy[WIDTH-1]);
  assign flg.half  = cy[HALF];
  assign flg.arith = is_arith;

endmodule

// File: rtl/ccr_next.sv
module ccr_next
  import alu_ccr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  alu_op_e          op,
  input  logic [7:0]       cur,
  input  logic [WIDTH-1:0] res,
  input  core_flags_t      flg,
  output logic [7:0]       nxt
);
  logic upd_carry;
  logic upd_half;

  assign upd_carry = (op == OP_ADD) || (op == OP_ADC) || (op == OP_SUB);
  assign upd_half  = (op == OP_ADD) || (op == OP_ADC);

  always_comb begin
    nxt        = cur;
    nxt[FLG_N] = res[WIDTH-1];
    nxt[FLG_Z] = (res == '0);
    nxt[FLG_V] = flg.arith ? flg.ovf : 1'b0;
    if (upd_carry) nxt[FLG_C] = flg.carry;
    if (upd_half)  nxt[FLG_H] = flg.half;
  end

endmodule

// File: rtl/branch_eval.sv
module branch_eval
  import alu_ccr_pkg::*;
(
  input  br_cond_e sel,
  input  logic     z,
  input  logic     c,
  output logic     taken
);
  always_comb begin
    unique case (sel)
      BR_EQ:   taken = z;
      BR_NE:   taken = ~z;
      BR_CC:   taken = ~c;
      default: taken = c;
    endcase
  end
endmodule

// File: rtl/alu_ccr_unit.sv
module alu_ccr_unit
  import alu_ccr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             op_valid,
  input  logic [2:0]       op_sel,
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_b,
  input  logic             ccr_wr_en,
  input  logic [7:0]       ccr_wr_data,
  input  logic [1:0]       br_sel,
  output logic [WIDTH-1:0] result,
  output logic [7:0]       ccr,
  output logic             br_taken
);
  alu_op_e          op_e;
  br_cond_e         br_e;
  logic [WIDTH-1:0] res_c;
  core_flags_t      flg_c;
  logic [7:0]       ccr_nx;
  logic             taken_c;

  assign op_e = alu_op_e'(op_sel);
  assign br_e = br_cond_e'(br_sel);

  alu_core #(.WIDTH(WIDTH)) u_core (
    .op  (op_e),
    .a   (opnd_a),
    .b   (opnd_b),
    .cin (ccr[FLG_C]),
    .res (res_c),
    .flg (flg_c)
  );

  ccr_next #(.WIDTH(WIDTH)) u_next (
    .op  (op_e),
    .cur (ccr),
    .res (res_c),
    .flg (flg_c),
    .nxt (ccr_nx)
  );

  branch_eval u_br (
    .sel   (br_e),
    .z     (ccr[FLG_Z]),
    .c     (ccr[FLG_C]),
    .taken (taken_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result   <= '0;
      ccr      <= CCR_RESET;
      br_taken <= 1'b0;
    end else begin
      br_taken <= taken_c;
      if (op_valid) result <= res_c;
      if (ccr_wr_en)     ccr <= ccr_wr_data;
      else if (op_valid) ccr <= ccr_nx;
    end
  end

endmodule

// File: rtl/alu_ccr_chk.sv
module alu_ccr_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             op_valid,
  input logic [2:0]       op_sel,
  input logic             ccr_wr_en,
  input logic [7:0]       ccr_wr_data,
  input logic [1:0]       br_sel,
  input logic [WIDTH-1:0] result,
  input logic [7:0]       ccr,
  input logic             br_taken
);
  // R9
  mask_bits_chk: assert property (@(posedge clk) disable iff (rst)
    (!ccr_wr_en) |=> $stable({ccr[7], ccr[6], ccr[4]}));

  // R10
  ccr_write_chk: assert property (@(posedge clk) disable iff (rst)
    ccr_wr_en |=> (ccr == $past(ccr_wr_data)));

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!ccr_wr_en && !op_valid) |=> ($stable(ccr) && $stable(result)));

  // R8
  half_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !ccr_wr_en && (op_sel > 3'd1)) |=> $stable(ccr[5]));

  // R5
  logic_flags_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !ccr_wr_en && (op_sel >= 3'd5)) |=> (!ccr[1] && $stable(ccr[0])));

  // R6
  nz_flags_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !ccr_wr_en) |=> ((ccr[3] == result[WIDTH-1]) && (ccr[2] == (result == '0))));

  // R12
  branch_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (br_taken == (($past(br_sel) == 2'd0) ?  $past(ccr[2]) :
                           ($past(br_sel) == 2'd1) ? !$past(ccr[2]) :
                           ($past(br_sel) == 2'd2) ? !$past(ccr[0]) : $past(ccr[0]))));
endmodule

bind alu_ccr_unit alu_ccr_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst(rst), .op_valid(op_valid), .op_sel(op_sel),
  .ccr_wr_en(ccr_wr_en), .ccr_wr_data(ccr_wr_data), .br_sel(br_sel),
  .result(result), .ccr(ccr), .br_taken(br_taken)
);

// File: tb/alu_ccr_unit_tb.sv
module alu_ccr_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       op_valid = 1'b0;
  logic [2:0] op_sel = '0;
  logic [7:0] opnd_a = '0;
  logic [7:0] opnd_b = '0;
  logic       ccr_wr_en = 1'b0;
  logic [7:0] ccr_wr_data = '0;
  logic [1:0] br_sel = '0;
  logic [7:0] result;
  logic [7:0] ccr;
  logic       br_taken;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu_ccr_unit u_dut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_sel(op_sel),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .ccr_wr_en(ccr_wr_en),
    .ccr_wr_data(ccr_wr_data), .br_sel(br_sel), .result(result),
    .ccr(ccr), .br_taken(br_taken)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit br_exp(input int sel, input int f);
    case (sel)
      0: return f[2];
      1: return !f[2];
      2: return !f[0];
      default: return f[0];
    endcase
  endfunction

  task automatic run_vec(input int op, input int a, input int b, input int pre);
    int r, c, v, h, cin;
    int bs;
    c = pre & 1; v = 0; h = (pre >> 5) & 1; cin = pre & 1;
    bs = (a ^ b) & 3;
    @(negedge clk);
    ccr_wr_en = 1'b1; ccr_wr_data = 8'(pre); op_valid = 1'b0;
    @(negedge clk);
    ccr_wr_en = 1'b0; op_valid = 1'b1; op_sel = 3'(op);
    opnd_a = 8'(a); opnd_b = 8'(b); br_sel = 2'(bs);
    @(negedge clk);
    op_valid = 1'b0;
    case (op)
      0, 1: begin
        if (op == 0) cin = 0;
        r = a + b + cin;
        c = (r >> 8) & 1;
        h = ((a & 15) + (b & 15) + cin) > 15 ? 1 : 0;
        r = r & 255;
        v = (((a ^ b) & 128) == 0 && ((r ^ a) & 128) != 0) ? 1 : 0;
      end
      2: begin
        r = (a - b) & 255;
        c = (a < b) ? 1 : 0;
        v = (((a ^ b) & 128) != 0 && ((r ^ a) & 128) != 0) ? 1 : 0;
      end
      3: begin r = (a + 1) & 255; v = (a == 127) ? 1 : 0; end
      4: begin r = (a - 1) & 255; v = (a == 128) ? 1 : 0; end
      5: r = a & b;
      6: r = a | b;
      default: r = a ^ b;
    endcase
    if (op <= 2)      chk($sformatf("R2/R3 add-sub result op=%0d", op), result, r);
    else if (op <= 4) chk("R4 inc-dec result", result, r);
    else              chk("R5 logic result", result, r);
    if (op <= 1)      chk("R2 carry", ccr[0], c);
    else if (op == 2) chk("R3 borrow", ccr[0], c);
    else              chk("R4/R5 carry kept", ccr[0], c);
    if (op <= 2)      chk("R7 overflow", ccr[1], v);
    else if (op <= 4) chk("R4 overflow", ccr[1], v);
    else              chk("R5 overflow cleared", ccr[1], v);
    chk("R6 negative", ccr[3], (r >> 7) & 1);
    chk("R6 zero", ccr[2], (r == 0) ? 1 : 0);
    chk("R8 half carry", ccr[5], h);
    chk("R9 mask bits", {ccr[7], ccr[6], ccr[4]}, ((pre >> 5) & 6) | ((pre >> 4) & 1));
    chk("R12 branch", br_taken, br_exp(bs, pre));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset result", result, 0);
    chk("R1 reset ccr", ccr, 8'hD0);
    chk("R1 reset branch", br_taken, 0);
    rst = 1'b0;
    chk("R1 first cycle ccr", ccr, 8'hD0);

    for (int op = 0; op < 8; op++)
      for (int a = 0; a < 256; a++)
        for (int b = 0; b < 256; b += 17)
          run_vec(op, a, b, (a * 7 + b * 13 + op * 29) & 255);

    // R10: operation and register write in the same cycle
    @(negedge clk);
    ccr_wr_en = 1'b1; ccr_wr_data = 8'h01;
    @(negedge clk);
    ccr_wr_data = 8'h3C; op_valid = 1'b1; op_sel = 3'd1;
    opnd_a = 8'h10; opnd_b = 8'h20;
    @(negedge clk);
    ccr_wr_en = 1'b0; op_valid = 1'b0;
    chk("R10 write wins ccr", ccr, 8'h3C);
    chk("R10 result with old carry", result, 8'h31);

    // R11: idle cycles hold state
    opnd_a = 8'hFF; opnd_b = 8'hFF; op_sel = 3'd0;
    repeat (3) @(negedge clk);
    chk("R11 hold result", result, 8'h31);
    chk("R11 hold ccr", ccr, 8'h3C);

    // R12: each condition on a known byte (Z=1, C=0 in 0x3C)
    for (int s = 0; s < 4; s++) begin
      br_sel = 2'(s);
      @(negedge clk);
      chk($sformatf("R12 branch sel=%0d", s), br_taken, (s == 0 || s == 2) ? 1 : 0);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule